// File: doc/BRIEF.md
# Boot ROM Overlay Address Decoder

This block sits between the processor's request bus and the two main memories of a 32-bit system. It chooses the chip select and the word address for each access, and it multiplexes the returned read data. After reset the boot ROM must appear at address zero so that the processor can fetch its reset vectors. While this overlay is active, every read in the low region (0x0000_0000–0x3FFF_FFFF) is served from ROM, with the ROM image repeated to fill the region. Every write to the low region is dropped. The ROM also stays visible at all times in a permanent window at 0x4000_0000–0x4FFF_FFFF.

The boot code leaves the overlay by reading anything in the permanent window. That read is still answered by ROM. From the next cycle on, the low region maps to main RAM for reads and writes, and it stays that way until the next reset.

Addresses arrive as word addresses (byte address bits 31:2), and four byte-lane enables qualify each access. The ROM and RAM are external storage with combinational read data. The block has two states:

- `OVL_BOOT`: overlay active. Entered by reset.
- `OVL_RUN`: low region mapped to RAM.

There is one transition, `leave_boot`, taken on a read that hits the permanent window while in `OVL_BOOT`. `OVL_RUN` has only the self-loop `hold_run`.

Top module: `boot_map_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, `overlay_on` is 1 (state `OVL_BOOT`).
- R2: In `OVL_BOOT`, a read in the low region asserts `rom_cs` and not `ram_cs`. It drives `rom_addr` = word address modulo (min(ROM size, 4 MiB)/4), so the ROM is mirrored across the region. It returns the ROM word.
- R3: In `OVL_BOOT`, a write to the low region asserts neither chip select, and RAM content is left unchanged.
- R4: In either state, a read with byte-address bits 31:28 = 0x4 asserts `rom_cs`. It drives `rom_addr` = word address modulo (ROM size/4) and returns the ROM word.
- R5: A write with byte-address bits 31:28 = 0x4 asserts no chip select and does not change the overlay state.
- R6: The first permanent-window read in `OVL_BOOT` still returns ROM data in its own cycle. `overlay_on` reads 0 from the following cycle.
- R7: In `OVL_RUN`, a low-region access asserts `ram_cs`, with `ram_we` = 1 for writes. It drives `ram_addr` = word address modulo (RAM size/4) and `ram_be` = `req_be`. A read returns the RAM word.
- R8: An access outside the low region and the permanent window asserts no chip select and reads as zero.
- R9: Byte lane i (bit i of `req_be`) covers `resp_rdata[8i+7:8i]`. A lane whose enable is 0 reads as zero, and writes always read as zero.
- R10: Once in `OVL_RUN`, the block stays there until reset, whatever the later accesses.
- R11: With `req_valid` = 0, no chip select is asserted and the state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_waddr | input | 30 | Word address (byte address bits 31:2) |
| req_be | input | 4 | Byte-lane enables |
| req_wdata | input | 32 | Write data |
| rom_rdata | input | 32 | ROM read data (combinational from `rom_addr`) |
| ram_rdata | input | 32 | RAM read data (combinational from `ram_addr`) |
| rom_cs | output | 1 | ROM selected for a read |
| rom_addr | output | 30 | ROM word index, already masked |
| ram_cs | output | 1 | RAM selected |
| ram_we | output | 1 | RAM write strobe (sampled by RAM at the clock edge) |
| ram_be | output | 4 | RAM byte-lane enables |
| ram_addr | output | 30 | RAM word index, already masked |
| ram_wdata | output | 32 | RAM write data |
| resp_rdata | output | 32 | Read data returned to the processor |
| overlay_on | output | 1 | 1 while the boot overlay is active |

## Verification
The assertions assume that `req_valid`, `req_write`, `req_waddr` and `req_be` are stable across each clock edge and defined whenever `req_valid` is 1. They also assume that the memories return data in the same cycle as the address. The stimulus meets these assumptions by changing inputs only on the falling edge, one request per cycle. It returns `req_valid` to 0 for idle cycles.

The sequence runs through the boot phase: vector fetches, including a mirrored address above the 4 MiB overlay span, a dropped low write, a permanent-window write and an unmapped read. It then takes a lane-masked permanent-window read that switches the map. After the switch it covers RAM traffic: full and partial writes, a read that shows the earlier dropped write never landed, an address that wraps past the RAM size, and further permanent-window reads.

// File: rtl/boot_map_pkg.sv
package boot_map_pkg;

    // Overlay state: boot (ROM at zero) or run (RAM at zero)
    typedef enum logic {
        OVL_BOOT = 1'b0,
        OVL_RUN  = 1'b1
    } ovl_state_e;

    // Which storage answers the current access
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_ROM  = 2'd1,
        TGT_RAM  = 2'd2
    } tgt_e;

    // Byte-address bits 31:28 of the permanent ROM window
    localparam logic [3:0] HI_WIN_TAG = 4'h4;
    // Byte-address bits 31:30 of the low region
    localparam logic [1:0] LO_REG_TAG = 2'b00;

    function automatic int min_int(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/bm_overlay_fsm.sv
module bm_overlay_fsm
    import boot_map_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hi_read,
    output logic overlay_on
);

    ovl_state_e state_q;
    ovl_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVL_BOOT: if (hi_read) state_d = OVL_RUN;   // leave_boot
            OVL_RUN:  state_d = OVL_RUN;                // hold_run
            default:  state_d = OVL_BOOT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OVL_BOOT;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            OVL_BOOT: overlay_on = 1'b1;
            OVL_RUN:  overlay_on = 1'b0;
            default:  overlay_on = 1'b1;
        endcase
    end

    // R6: a window read during boot moves to run on the next cycle
    assert_leave_boot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (overlay_on && hi_read) |=> !overlay_on);

    // R10: run state is never left without reset
    assert_run_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !overlay_on |=> !overlay_on);

    // R5, R11: without a window read the boot state is held
    assert_boot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (overlay_on && !hi_read) |=> overlay_on);

endmodule

// File: rtl/bm_region_decode.sv
module bm_region_decode
    import boot_map_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int ROM_BYTES     = 8 * 1024 * 1024,
    parameter int RAM_BYTES     = 4 * 1024 * 1024,
    parameter int OVL_MAX_BYTES = 4 * 1024 * 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              overlay_on,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-3:0] req_waddr,
    output tgt_e              tgt,
    output logic [ADDR_W-3:0] rom_waddr,
    output logic [ADDR_W-3:0] ram_waddr,
    output logic              hi_read
);

    localparam int WA_W      = ADDR_W - 2;
    localparam int OVL_BYTES = min_int(ROM_BYTES, OVL_MAX_BYTES);
    localparam logic [WA_W-1:0] ROM_WMASK = WA_W'(ROM_BYTES / 4 - 1);
    localparam logic [WA_W-1:0] OVL_WMASK = WA_W'(OVL_BYTES / 4 - 1);
    localparam logic [WA_W-1:0] RAM_WMASK = WA_W'(RAM_BYTES / 4 - 1);

    logic lo_hit;
    logic hi_hit;

    assign lo_hit  = (req_waddr[WA_W-1 -: 2] == LO_REG_TAG);
    assign hi_hit  = (req_waddr[WA_W-1 -: 4] == HI_WIN_TAG);
    assign hi_read = req_valid && !req_write && hi_hit;

    assign ram_waddr = req_waddr & RAM_WMASK;

    always_comb begin
        tgt       = TGT_NONE;
        rom_waddr = req_waddr & ROM_WMASK;
        if (req_valid) begin
            if (hi_hit) begin
                if (!req_write) tgt = TGT_ROM;       // window writes dropped
            end else if (lo_hit) begin
                if (overlay_on) begin
                    rom_waddr = req_waddr & OVL_WMASK;
                    if (!req_write) tgt = TGT_ROM;   // boot writes dropped
                end else begin
                    tgt = TGT_RAM;
                end
            end
        end
    end

    // R3: during boot a low-region write reaches no storage
    assert_boot_write_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (overlay_on && req_valid && req_write && lo_hit) |-> (tgt == TGT_NONE));

    // R5: a permanent-window write selects nothing
    assert_hi_write_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && hi_hit) |-> (tgt == TGT_NONE));

    // R7: after boot, low-region accesses go to RAM
    assert_run_ram_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!overlay_on && req_valid && lo_hit) |-> (tgt == TGT_RAM));

    // R2: the overlay index stays within the overlay span
    assert_ovl_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (overlay_on && req_valid && lo_hit) |-> ((rom_waddr & ~OVL_WMASK) == '0));

endmodule

// File: rtl/bm_rdata_mux.sv
module bm_rdata_mux
    import boot_map_pkg::*;
#(
    parameter int LANES = 4
) (
    input  tgt_e               tgt,
    input  logic               is_read,
    input  logic [LANES-1:0]   be,
    input  logic [8*LANES-1:0] rom_rdata,
    input  logic [8*LANES-1:0] ram_rdata,
    output logic [8*LANES-1:0] rdata
);

    logic [8*LANES-1:0] word;

    always_comb begin
        word = '0;
        if (is_read) begin
            unique case (tgt)
                TGT_ROM:  word = rom_rdata;
                TGT_RAM:  word = ram_rdata;
                default:  word = '0;
            endcase
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign rdata[8*i +: 8] = be[i] ? word[8*i +: 8] : 8'h00;
    end

endmodule

// File: rtl/boot_map_decoder.sv
module boot_map_decoder
    import boot_map_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int DATA_W        = 32,
    parameter int ROM_BYTES     = 8 * 1024 * 1024,
    parameter int RAM_BYTES     = 4 * 1024 * 1024,
    parameter int OVL_MAX_BYTES = 4 * 1024 * 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-3:0]   req_waddr,
    input  logic [DATA_W/8-1:0] req_be,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W-1:0]   rom_rdata,
    input  logic [DATA_W-1:0]   ram_rdata,
    output logic                rom_cs,
    output logic [ADDR_W-3:0]   rom_addr,
    output logic                ram_cs,
    output logic                ram_we,
    output logic [DATA_W/8-1:0] ram_be,
    output logic [ADDR_W-3:0]   ram_addr,
    output logic [DATA_W-1:0]   ram_wdata,
    output logic [DATA_W-1:0]   resp_rdata,
    output logic                overlay_on
);

    localparam int LANES = DATA_W / 8;

    tgt_e tgt;
    logic hi_read;

    bm_overlay_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hi_read    (hi_read),
        .overlay_on (overlay_on)
    );

    bm_region_decode #(
        .ADDR_W        (ADDR_W),
        .ROM_BYTES     (ROM_BYTES),
        .RAM_BYTES     (RAM_BYTES),
        .OVL_MAX_BYTES (OVL_MAX_BYTES)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .overlay_on (overlay_on),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_waddr  (req_waddr),
        .tgt        (tgt),
        .rom_waddr  (rom_addr),
        .ram_waddr  (ram_addr),
        .hi_read    (hi_read)
    );

    bm_rdata_mux #(.LANES(LANES)) u_mux (
        .tgt       (tgt),
        .is_read   (!req_write),
        .be        (req_be),
        .rom_rdata (rom_rdata),
        .ram_rdata (ram_rdata),
        .rdata     (resp_rdata)
    );

    assign rom_cs    = (tgt == TGT_ROM);
    assign ram_cs    = (tgt == TGT_RAM);
    assign ram_we    = ram_cs && req_write;
    assign ram_be    = req_be;
    assign ram_wdata = req_wdata;

    // R11: idle bus selects nothing
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!rom_cs && !ram_cs));

    // R8: chip selects are never both active
    assert_cs_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_cs && ram_cs));

    // R9: writes return no data
    assert_write_no_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |-> (resp_rdata == '0));

endmodule

// File: tb/tb_boot_map_decoder.sv
`timescale 1ns/100ps
module tb_boot_map_decoder;

    localparam int ROM_BYTES = 8 * 1024 * 1024;
    localparam int RAM_BYTES = 16 * 1024;
    localparam int OVL_BYTES = 4 * 1024 * 1024;
    localparam int RAM_WORDS = RAM_BYTES / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [29:0] req_waddr = '0;
    logic [3:0]  req_be = 4'hF;
    logic [31:0] req_wdata = '0;
    logic [31:0] rom_rdata, ram_rdata;
    logic        rom_cs, ram_cs, ram_we, overlay_on;
    logic [29:0] rom_addr, ram_addr;
    logic [3:0]  ram_be;
    logic [31:0] ram_wdata, resp_rdata;

    always #2.5 clk = ~clk;   // 200 MHz

    boot_map_decoder #(.ROM_BYTES(ROM_BYTES), .RAM_BYTES(RAM_BYTES)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_waddr(req_waddr), .req_be(req_be), .req_wdata(req_wdata),
        .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .rom_cs(rom_cs),
        .rom_addr(rom_addr), .ram_cs(ram_cs), .ram_we(ram_we), .ram_be(ram_be),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .resp_rdata(resp_rdata),
        .overlay_on(overlay_on)
    );

    // behavioural storage
    function automatic logic [31:0] rom_word(input logic [29:0] i);
        return {i[15:0] ^ 16'h5A3C, i[29:14]};
    endfunction

    logic [31:0] ram_arr [RAM_WORDS];
    assign rom_rdata = rom_word(rom_addr);
    assign ram_rdata = ram_arr[ram_addr[11:0]];
    always @(posedge clk)
        if (ram_cs && ram_we)
            for (int l = 0; l < 4; l++)
                if (ram_be[l]) ram_arr[ram_addr[11:0]][8*l +: 8] <= ram_wdata[8*l +: 8];

    // scoreboard
    typedef struct {
        string       tag;
        logic        rom_cs, ram_cs, ram_we, ovl;
        logic [29:0] addr;
        logic [31:0] rdata;
    } exp_t;
    exp_t sbq[$];

    int n_chk = 0, n_bad = 0;
    bit model_ovl = 1'b1;
    logic [31:0] shadow [RAM_WORDS];
    bit done = 1'b0;

    task automatic do_req(input string tag, input bit v, input bit w,
                          input logic [31:0] baddr, input logic [3:0] be,
                          input logic [31:0] wd);
        exp_t e;
        logic [29:0] wa;
        logic [31:0] raw;
        bit hi, lo;
        @(negedge clk);
        wa = baddr[31:2];
        req_valid = v; req_write = w; req_waddr = wa; req_be = be; req_wdata = wd;
        hi = (baddr[31:28] == 4'h4);
        lo = (baddr[31:30] == 2'b00);
        e.tag = tag; e.rom_cs = 0; e.ram_cs = 0; e.ram_we = 0;
        e.addr = '0; e.rdata = '0; e.ovl = model_ovl;
        raw = '0;
        if (v) begin
            if (hi && !w) begin
                e.rom_cs = 1; e.addr = 30'((baddr & (ROM_BYTES - 1)) >> 2);
                raw = rom_word(e.addr);
            end else if (lo && model_ovl && !w) begin
                e.rom_cs = 1; e.addr = 30'((baddr & (OVL_BYTES - 1)) >> 2);
                raw = rom_word(e.addr);
            end else if (lo && !model_ovl) begin
                e.ram_cs = 1; e.ram_we = w; e.addr = 30'((baddr & (RAM_BYTES - 1)) >> 2);
                if (w) begin
                    for (int l = 0; l < 4; l++)
                        if (be[l]) shadow[e.addr[11:0]][8*l +: 8] = wd[8*l +: 8];
                end else raw = shadow[e.addr[11:0]];
            end
        end
        for (int l = 0; l < 4; l++) e.rdata[8*l +: 8] = be[l] ? raw[8*l +: 8] : 8'h00;
        sbq.push_back(e);
        if (v && !w && hi) model_ovl = 1'b0;
    endtask

    always @(negedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            exp_t e;
            logic [29:0] act_addr;
            e = sbq.pop_front();
            act_addr = rom_cs ? rom_addr : (ram_cs ? ram_addr : 30'h0);
            n_chk++;
            if (rom_cs !== e.rom_cs || ram_cs !== e.ram_cs || ram_we !== e.ram_we ||
                act_addr !== e.addr || resp_rdata !== e.rdata || overlay_on !== e.ovl) begin
                n_bad++;
                $display("FAIL %s: act rom_cs=%b ram_cs=%b we=%b addr=%h rdata=%h ovl=%b / exp rom_cs=%b ram_cs=%b we=%b addr=%h rdata=%h ovl=%b",
                         e.tag, rom_cs, ram_cs, ram_we, act_addr, resp_rdata, overlay_on,
                         e.rom_cs, e.ram_cs, e.ram_we, e.addr, e.rdata, e.ovl);
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #5000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act running exp finished");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < RAM_WORDS; i++) begin ram_arr[i] = '0; shadow[i] = '0; end
        #1;
        n_chk++;   // R1 during reset
        if (overlay_on !== 1'b1) begin
            n_bad++;
            $display("FAIL R1 reset: act ovl=%b exp 1", overlay_on);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        do_req("R1_R11 idle after reset", 0, 0, 32'h0000_0000, 4'hF, 0);
        do_req("R2 vector fetch 0x0",     1, 0, 32'h0000_0000, 4'hF, 0);
        do_req("R2 vector fetch 0x4",     1, 0, 32'h0000_0004, 4'hF, 0);
        do_req("R2 mirror above span",    1, 0, 32'h0040_0008, 4'hF, 0);
        do_req("R2 inside span",          1, 0, 32'h0010_0000, 4'hF, 0);
        do_req("R3 boot write dropped",   1, 1, 32'h0000_0010, 4'hF, 32'hCAFE_F00D);
        do_req("R5 window write ignored", 1, 1, 32'h4000_0000, 4'hF, 32'h1111_2222);
        do_req("R5 still boot",           1, 0, 32'h0000_0000, 4'hF, 0);
        do_req("R8 unmapped read",        1, 0, 32'h5000_0000, 4'hF, 0);
        do_req("R4_R6_R9 window read",    1, 0, 32'h4FF0_0010, 4'b0011, 0);
        do_req("R3_R7 dropped write gone",1, 0, 32'h0000_0010, 4'hF, 0);
        do_req("R7 full write 0x0",       1, 1, 32'h0000_0000, 4'hF, 32'h1234_5678);
        do_req("R7 readback 0x0",         1, 0, 32'h0000_0000, 4'hF, 0);
        do_req("R7_R9 lane write",        1, 1, 32'h0000_0000, 4'b0100, 32'hAABB_CCDD);
        do_req("R7 lane readback",        1, 0, 32'h0000_0000, 4'hF, 0);
        do_req("R7 ram wrap",             1, 0, 32'h0000_4000, 4'hF, 0);
        do_req("R9 masked ram read",      1, 0, 32'h0000_0000, 4'b1001, 0);
        do_req("R4_R10 window read run",  1, 0, 32'h4000_0004, 4'hF, 0);
        do_req("R10 still run",           1, 0, 32'h0000_0004, 4'hF, 0);
        do_req("R11 idle in run",         0, 1, 32'h0000_0000, 4'hF, 32'hFFFF_FFFF);
        do_req("R11 write not landed",    1, 0, 32'h0000_0000, 4'hF, 0);
        do_req("R8 unmapped write",       1, 1, 32'h8000_0000, 4'hF, 32'h5555_5555);
        do_req("R11 idle end",            0, 0, 32'h0000_0000, 4'hF, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule